// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request port and a byte-wide static RAM that has no clock of its own. A requester offers a single read or write with a valid/ready handshake. The controller latches address and write data and plays out the RAM's control-pin sequence, using pulse lengths counted in system clock cycles. It returns read data with a one-cycle valid pulse. The RAM has a 17-bit address, an 8-bit shared data bus, an active-low chip enable, an active-high chip select, an active-low output enable and an active-low write enable.

A write starts with a setup cycle in which the chip is selected, the address is stable and the controller's data drivers are on. A write-enable pulse of `T_WP` cycles follows, then one hold cycle. The write pulse always closes before the chip enable, and output enable stays high for the whole write. A read keeps the chip selected for `T_RD` cycles and lowers output enable only in the last `T_OE` of them. The data bus is sampled on the final read cycle. After every read the device is deselected for `T_TURN` cycles, so that the RAM has released the bus before any later write drives it. Between accesses the controller stays in a standby state: chip deselected, all strobes high, drivers off. The address changes only while the chip is deselected. Every timing parameter must be at least 1.

Top module: `sram_ctrl`

## Requirements
- R1: During reset (asynchronous, active-low) and when idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_cs` is 0, `mem_dq_oe` is 0, `rvalid` is 0 and `req_ready` is 1.
- R2: A read accepted on a clock edge holds `mem_ce_n`=0, `mem_cs`=1 and `mem_we_n`=1 for the next `T_RD` cycles. `req_ready` is 0 from acceptance until `T_RD+T_TURN` cycles have passed, and is 1 in the cycle after that.
- R3: `mem_oe_n` is 0 only during the last `T_OE` cycles of a read (clamped to `T_RD`). It is 1 throughout every write, and never 0 while `mem_we_n` is 0.
- R4: Read data is sampled from `mem_dq_in` on the last read cycle. `rdata` carries it, and `rvalid` is high for exactly one cycle, the one after the last read cycle.
- R5: A write accepted on a clock edge gives one setup cycle (`mem_ce_n`=0, `mem_we_n`=1), then `mem_we_n`=0 for exactly `T_WP` cycles, then one hold cycle (`mem_ce_n`=0, `mem_we_n`=1). `req_ready` returns `T_WP+2` cycles after acceptance.
- R6: While the chip stays selected, `mem_addr` does not change. While `mem_dq_oe` stays 1, `mem_dq_out` does not change. `mem_dq_out` equals the accepted write data.
- R7: `mem_dq_oe` is 1 only in the three write phases and never while `mem_oe_n` is 0. Before it rises, at least `T_TURN` cycles with `mem_oe_n`=1 have passed since the last cycle with `mem_oe_n`=0.
- R8: A request presented while `req_ready` is 0 is not accepted and causes no memory access; a write offered then leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| rvalid | output | 1 | One-cycle pulse: rdata holds read result |
| rdata | output | 8 | Read result |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_cs | output | 1 | RAM chip select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
Two events can meet on the shared bus: the RAM releasing its drive at the end of a read, and the controller turning on its drivers for the write that follows. The bench provokes this by keeping requests back to back with no idle gap, alternating a write and a read to the same address across a sweep of walking-one, boundary and sequential addresses. On every cycle a RAM model records any overlap of its own drive with `mem_dq_oe`, and measures the gap between the last output-enable cycle and the rise of the drivers against `T_TURN`. Requests that arrive while busy are also offered during reads, and the addresses they name are read back afterwards.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } sram_st_t;
endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int T_RD   = 3,
  parameter int T_OE   = 2,
  parameter int T_WP   = 3,
  parameter int T_TURN = 1,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_zero,
  input  logic [CNT_W-1:0] cnt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             cs,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);
  localparam int OE_WIN = (T_OE > T_RD) ? T_RD : T_OE;
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(T_RD - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(T_TURN - 1);
  localparam logic [CNT_W-1:0] OE_CMP  = CNT_W'(OE_WIN);

  sram_st_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (req_write) begin
          st_d = ST_WSETUP;
        end else begin
          st_d     = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = RD_LD;
        end
      end
      ST_READ: if (cnt_zero) begin
        capture  = 1'b1;
        st_d     = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TURN_LD;
      end
      ST_TURN:   if (cnt_zero) st_d = ST_IDLE;
      ST_WSETUP: begin
        st_d     = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      ST_WPULSE: if (cnt_zero) st_d = ST_WHOLD;
      ST_WHOLD:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  logic in_write, selected;
  assign in_write = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
  assign selected = in_write || (st_q == ST_READ);

  assign ready = (st_q == ST_IDLE);
  assign ce_n  = !selected;
  assign cs    = selected;
  assign we_n  = (st_q != ST_WPULSE);
  assign oe_n  = !((st_q == ST_READ) && (cnt < OE_CMP));
  assign dq_oe = in_write;

  // Checker state: cycles with output enable high since it was last low.
  localparam int GAP_W = $clog2(T_TURN + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(T_TURN);
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_q <= GAP_SAT;
    else if (!oe_n)           gap_q <= '0;
    else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && !cs && we_n && oe_n && !dq_oe));
  assert_we_oe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  assert_we_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (!ce_n && $past(!ce_n)));
  assert_we_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !ce_n);
  assert_drive_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (gap_q >= GAP_SAT));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              rvld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (capture) rdat_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvld_q <= 1'b0;
    else        rvld_q <= capture;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign rdata      = rdat_q;
  assign rvalid     = rvld_q;

  assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_RD   = 3,
  parameter int T_OE   = 2,
  parameter int T_WP   = 3,
  parameter int T_TURN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int MAX_RW = (T_RD > T_WP) ? T_RD : T_WP;
  localparam int MAX_T  = (MAX_RW > T_TURN) ? MAX_RW : T_TURN;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;

  sram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .zero(tmr_zero)
  );

  sram_seq #(
    .T_RD(T_RD), .T_OE(T_OE), .T_WP(T_WP), .T_TURN(T_TURN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cnt_zero(tmr_zero), .cnt(tmr_cnt), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept), .capture(capture), .ready(req_ready),
    .ce_n(mem_ce_n), .cs(mem_cs), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rdata(rdata), .rvalid(rvalid)
  );

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_ce_n && $past(!mem_ce_n)) |=> $stable(mem_addr) || mem_ce_n);
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int T_RD = 3, T_OE = 2, T_WP = 3, T_TURN = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready, rvalid;
  logic [16:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rdata, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;

  always #10 clk = ~clk;

  sram_ctrl #(.T_RD(T_RD), .T_OE(T_OE), .T_WP(T_WP), .T_TURN(T_TURN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  logic [7:0] ram  [int];
  logic [7:0] expm [int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // RAM model: drives only when selected, reading, output enabled.
  logic model_drive;
  assign model_drive = !mem_ce_n && mem_cs && mem_we_n && !mem_oe_n;
  always @(*) begin
    if (model_drive) mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'hA5;
    else             mem_dq_in = 8'h00;
  end

  int we_run, oe_run, since_oe;
  int bad_wp = 0, bad_oe = 0, bad_weoe = 0, bad_cont = 0, bad_addr = 0;
  int bad_data = 0, bad_turn = 0, bad_wdrive = 0;
  logic prev_sel, prev_doe;
  logic [16:0] prev_addr;
  logic [7:0]  prev_dout;

  always @(negedge clk) begin
    if (!rst_n) begin
      we_run = 0; oe_run = 0; since_oe = 100; prev_sel = 1'b0; prev_doe = 1'b0;
    end else begin
      if (!mem_we_n) we_run++;
      else begin
        if (we_run != 0) begin
          if (we_run != T_WP) bad_wp++;
          if (!mem_ce_n && mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;
          else bad_wdrive++;
        end
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else begin
        if (oe_run != 0 && oe_run != T_OE) bad_oe++;
        oe_run = 0;
      end
      if (!mem_we_n && !mem_oe_n) bad_weoe++;
      if (mem_dq_oe && model_drive) bad_cont++;
      if (!mem_ce_n && prev_sel && mem_addr != prev_addr) bad_addr++;
      if (mem_dq_oe && prev_doe && mem_dq_out != prev_dout) bad_data++;
      if (!mem_oe_n) since_oe = 0; else since_oe++;
      if (mem_dq_oe && !prev_doe && since_oe <= T_TURN) bad_turn++;
      prev_sel = !mem_ce_n; prev_doe = mem_dq_oe;
      prev_addr = mem_addr; prev_dout = mem_dq_out;
    end
  end

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'(a * 29 + (a >>> 9) + s * 71 + 3);
  endfunction

  task automatic wait_accept();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int seq_bad = 0, oe_bad = 0, rdy_bad = 0, dat_bad = 0;
    int last = T_WP + 3;
    req_addr = a; req_wdata = d; req_write = 1'b1; req_valid = 1'b1;
    wait_accept();
    req_valid = 1'b0;
    for (int k = 1; k <= last; k++) begin
      if (mem_we_n != !(k >= 2 && k <= T_WP + 1)) seq_bad++;
      if (mem_ce_n != (k == last) || mem_cs != (k != last)) seq_bad++;
      if (mem_dq_oe != (k < last)) seq_bad++;
      if (k < last && mem_dq_out != d) dat_bad++;
      if (!mem_oe_n) oe_bad++;
      if (req_ready != (k == last)) rdy_bad++;
      if (k < last) @(negedge clk);
    end
    expm[int'(a)] = d;
    chk(seq_bad == 0, "R5 write pin sequence", seq_bad, 0);
    chk(rdy_bad == 0, "R5 write ready timing", rdy_bad, 0);
    chk(oe_bad == 0,  "R3 oe high in write", oe_bad, 0);
    chk(dat_bad == 0, "R6 write data on bus", dat_bad, 0);
  endtask

  task automatic do_read(input logic [16:0] a, input bit noise);
    int seq_bad = 0, oe_bad = 0, rv_bad = 0, rdy_bad = 0;
    int last = T_RD + T_TURN + 1;
    logic [7:0] e, got;
    e = expm.exists(int'(a)) ? expm[int'(a)] : 8'hA5;
    got = 8'h00;
    req_addr = a; req_write = 1'b0; req_valid = 1'b1;
    wait_accept();
    req_valid = 1'b0;
    for (int k = 1; k <= last; k++) begin
      if (mem_ce_n != (k > T_RD) || mem_cs != (k <= T_RD) || !mem_we_n || mem_dq_oe) seq_bad++;
      if (mem_oe_n != !(k > T_RD - T_OE && k <= T_RD)) oe_bad++;
      if (rvalid != (k == T_RD + 1)) rv_bad++;
      if (k == T_RD + 1) got = rdata;
      if (req_ready != (k == last)) rdy_bad++;
      if (k < last) begin
        if (noise) begin
          req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 17'h00155; req_wdata = 8'h3C;
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    chk(seq_bad == 0, "R2 read pin sequence", seq_bad, 0);
    chk(rdy_bad == 0, "R2 read ready timing", rdy_bad, 0);
    chk(oe_bad == 0,  "R3 oe window in read", oe_bad, 0);
    chk(rv_bad == 0,  "R4 rvalid single pulse", rv_bad, 0);
    chk(got == e,     "R4 read data", int'(got), int'(e));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rvalid && req_ready,
        "R1 reset pins", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, rvalid, req_ready},
        7'b1011001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R1 idle pins",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);

    // Phase 1: writes across walking-one, boundary and sequential addresses.
    for (int b = 0; b < 17; b++) do_write(17'(1 << b), pat(1 << b, 0));
    do_write(17'h00000, pat(0, 0));
    do_write(17'h1FFFF, pat(17'h1FFFF, 0));
    for (int i = 0; i < 16; i++) do_write(17'h00A00 + 17'(i), pat(17'hA00 + i, 0));

    // Phase 2: back-to-back reads of all of them.
    for (int b = 0; b < 17; b++) do_read(17'(1 << b), 1'b0);
    do_read(17'h00000, 1'b0);
    do_read(17'h1FFFF, 1'b0);
    for (int i = 0; i < 16; i++) do_read(17'h00A00 + 17'(i), 1'b0);

    // Phase 3: read->write->read with no gap, busy-time requests on odd steps (R8).
    for (int i = 0; i < 16; i++) begin
      logic [16:0] a;
      a = 17'h00A00 + 17'(i);
      do_read(a, 1'b0);
      do_write(a, pat(a, 1));
      do_read(a, i[0]);
    end
    for (int i = 1; i < 16; i += 2) do_read((17'h00A00 + 17'(i)) ^ 17'h00155, 1'b0);  // R8 readback

    // Reset in the middle of a write pulse returns the pins to idle (R1).
    req_addr = 17'h1F0F0; req_wdata = 8'h77; req_write = 1'b1; req_valid = 1'b1;
    wait_accept();
    req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_we_n, "R5 pulse active before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #2;
    chk(mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rvalid && req_ready,
        "R1 mid-write reset", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, rvalid, req_ready},
        7'b1011001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_write(17'h00003, 8'h5E);
    do_read(17'h00003, 1'b1);

    chk(bad_wp == 0,     "R5 write pulse width", bad_wp, 0);
    chk(bad_wdrive == 0, "R5 data driven at pulse end", bad_wdrive, 0);
    chk(bad_oe == 0,     "R3 oe run length", bad_oe, 0);
    chk(bad_weoe == 0,   "R3 we/oe overlap", bad_weoe, 0);
    chk(bad_cont == 0,   "R7 bus contention", bad_cont, 0);
    chk(bad_turn == 0,   "R7 turnaround gap", bad_turn, 0);
    chk(bad_addr == 0,   "R6 address stable while selected", bad_addr, 0);
    chk(bad_data == 0,   "R6 write data stable", bad_data, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule